// File: doc/BRIEF.md
# Four-Mode Serial Port with Address Filtering

This block is a full-duplex serial port. A single data write launches a transmission. The receiver has its own shift register and a separate holding register, so a new frame can be shifting in while software still owns the previous byte. One mode is synchronous: eight bits go out or come in on a data pin, and the port drives a shift clock on its second pin. In the other three modes the port sends and receives asynchronous frames. One of these frames has ten bits. The other two have eleven bits and carry a ninth data bit.

Bit timing comes from an external baud tick. In the asynchronous modes the tick runs at sixteen times the bit rate. The receiver takes three samples around mid-bit and decides each bit by majority. When the multiprocessor enable is set, the receiver drops any eleven-bit frame whose ninth bit is 0, and any ten-bit frame whose stop bit is not 1. A node can therefore sleep through data traffic and wake only on address frames.

Top module: `ser_port`

## Requirements
- R1: In mode 0 (mode = 0), a write sends the 8 bits LSB first on `dat_o` with `dat_oe` high. Each bit lasts two baud ticks: `txd_o` is low for the first tick and high for the second. `tx_done` rises in the cycle after the eighth bit ends, and `dat_oe` falls at the same time.
- R2: In modes 1 to 3, `txd_o` idles at 1. A frame is a 0 start bit, then the 8 data bits LSB first, then `tx_bit9` (modes 2 and 3 only), then a 1 stop bit. Each bit lasts 16 baud ticks.
- R3: In modes 1 to 3, `tx_done` goes to 1 in the first cycle of the stop bit. It is still 0 during the preceding bit. It stays at 1 until `clr_tx_done` is pulsed.
- R4: A pulse on `wr_stb` starts a transmission in every mode.
- R5: In mode 0, a reception starts when `rx_en` is 1, `rx_done` is 0 and no transmission is running. The port samples `rxd_i` at each rising edge of the clock on `txd_o` and assembles 8 bits LSB first. It then sets `rx_done` and clears `rx_bit9`, whatever the value of `mp_en`.
- R6: In modes 1 to 3, with `rx_en` at 1, a frame starts when a 1 followed by a 0 is seen on successive ticks. Each bit is the majority of its samples on ticks 7, 8 and 9 of the bit. If the start bit votes 1, the frame is rejected and nothing is loaded.
- R7: After a reception, `rx_bit9` holds the stop bit in mode 1 and the ninth bit in modes 2 and 3. In modes 2 and 3 the value of the stop bit has no effect.
- R8: In modes 2 and 3 with `mp_en` at 1, a frame whose ninth bit is 0 leaves `rx_done`, `rx_data` and `rx_bit9` unchanged.
- R9: In mode 1 with `mp_en` at 1, a frame whose stop bit is 0 is dropped. With `mp_en` at 0, the same frame is accepted and `rx_bit9` becomes 0.
- R10: A frame that completes while `rx_done` is still 1 is lost. `rx_data` and `rx_bit9` keep the earlier frame, and `rx_done` stays at 1 until `clr_rx_done` is pulsed.
- R11: In modes 1 to 3, when `rx_en` is 0, no incoming frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One tick per sample period (16 per bit in async modes, 2 per bit in mode 0) |
| mode | input | 2 | 0 = synchronous shift, 1 = 10-bit async, 2 and 3 = 11-bit async |
| rx_en | input | 1 | Receive enable |
| mp_en | input | 1 | Multiprocessor address filter enable |
| tx_bit9 | input | 1 | Ninth bit sent in modes 2 and 3 |
| wr_stb | input | 1 | Data write strobe; starts a transmission |
| wr_data | input | DATA_W | Byte to send |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| rxd_i | input | 1 | Serial input (data pin input in mode 0) |
| txd_o | output | 1 | Serial output, or shift clock in mode 0 |
| dat_o | output | 1 | Mode 0 data output |
| dat_oe | output | 1 | Output enable for `dat_o` |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| rx_bit9 | output | 1 | Received ninth bit or stop bit |
| rx_data | output | DATA_W | Received byte |

## Verification
The assertions assume that `mode` and `mp_en` stay constant for as long as a frame is moving in either direction. They also assume that no mode 0 transmission is started while a mode 0 reception is running, because both share the clock pin. The stimulus changes `mode` and `mp_en` only between frames. It waits for the transmitter to go idle and the receiver to report before it writes again, and it leaves `rx_en` low during mode 0 transmissions. The asynchronous input is driven at exactly sixteen ticks per bit, with one deliberate single-sample glitch.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

  typedef enum logic [1:0] {
    MD_SYNC  = 2'd0,
    MD_A10   = 2'd1,
    MD_A11   = 2'd2,
    MD_A11B  = 2'd3
  } sp_mode_e;

  // majority of three samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // frame carries an extra data bit before the stop bit
  function automatic logic has_bit9(input logic [1:0] m);
    return m[1];
  endfunction

  // decide whether a finished frame may enter the holding register
  function automatic logic rx_accept(input logic [1:0] m, input logic mp,
                                     input logic last_bit, input logic full);
    if (full) return 1'b0;
    if (m == MD_SYNC) return 1'b1;
    return !mp || last_bit;
  endfunction

endpackage

// File: rtl/ser_port_tx.sv
module ser_port_tx
  import ser_port_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9,
  output logic              busy,
  output logic              done_evt,
  output logic              line_o,
  output logic              sclk_o
);

  localparam int FW = DATA_W + 3;
  localparam int IW = $clog2(FW);
  localparam int SW = $clog2(OVERSAMPLE);
  localparam logic [IW-1:0] LAST_SYNC = IW'(DATA_W - 1);
  localparam logic [IW-1:0] LAST_A10  = IW'(DATA_W + 1);
  localparam logic [IW-1:0] LAST_A11  = IW'(DATA_W + 2);
  localparam logic [SW-1:0] SUB_SYNC  = SW'(1);
  localparam logic [SW-1:0] SUB_ASYNC = SW'(OVERSAMPLE - 1);

  logic [FW-1:0] frame_q, frame_d;
  logic [IW-1:0] idx_q, last_idx;
  logic [SW-1:0] sub_q, sub_last;
  logic          sync, step;

  always_comb begin
    sync     = (mode == MD_SYNC);
    last_idx = sync ? LAST_SYNC : (has_bit9(mode) ? LAST_A11 : LAST_A10);
    sub_last = sync ? SUB_SYNC : SUB_ASYNC;
    step     = busy && tick && (sub_q == sub_last);
    if (sync)                frame_d = {3'b111, wr_data};
    else if (has_bit9(mode)) frame_d = {1'b1, bit9, wr_data, 1'b0};
    else                     frame_d = {2'b11, wr_data, 1'b0};
  end

  // stop bit begins on the next edge in async modes; end of last bit in sync mode
  assign done_evt = step && (sync ? (idx_q == last_idx) : (idx_q == last_idx - 1'b1));
  assign line_o   = busy ? frame_q[idx_q] : 1'b1;
  assign sclk_o   = (busy && sync) ? sub_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      frame_q <= '1;
      idx_q   <= '0;
      sub_q   <= '0;
    end else if (wr_stb) begin
      busy    <= 1'b1;
      frame_q <= frame_d;
      idx_q   <= '0;
      sub_q   <= '0;
    end else if (busy && tick) begin
      if (sub_q == sub_last) begin
        sub_q <= '0;
        if (idx_q == last_idx) busy  <= 1'b0;
        else                   idx_q <= idx_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ser_port_rx.sv
module ser_port_rx
  import ser_port_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              rx_en,
  input  logic              hold_full,
  input  logic              tx_busy,
  input  logic              line_i,
  output logic              busy,
  output logic              sclk_o,
  output logic              end_evt,
  output logic [DATA_W-1:0] end_data,
  output logic              end_b9
);

  localparam int IW = $clog2(DATA_W + 2);
  localparam int SW = $clog2(OVERSAMPLE);
  localparam logic [SW-1:0] MID_LO   = SW'(OVERSAMPLE / 2 - 1);
  localparam logic [SW-1:0] MID      = SW'(OVERSAMPLE / 2);
  localparam logic [SW-1:0] MID_HI   = SW'(OVERSAMPLE / 2 + 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(OVERSAMPLE - 1);
  localparam logic [IW-1:0] LAST_SYNC  = IW'(DATA_W - 1);
  localparam logic [IW-1:0] LAST_ASYNC = IW'(DATA_W + 1);

  logic [DATA_W-1:0] dat_q;
  logic [IW-1:0]     idx_q;
  logic [SW-1:0]     sub_q;
  logic              s_lo, s_mid, line_q;
  logic              sync, vote, sync_start, async_start, judge;

  always_comb begin
    sync        = (mode == MD_SYNC);
    vote        = vote3(s_lo, s_mid, line_i);
    sync_start  = !busy && sync && rx_en && !hold_full && !tx_busy;
    async_start = !busy && !sync && rx_en && tick && line_q && !line_i;
    judge       = busy && !sync && tick && (sub_q == MID_HI);
  end

  assign end_evt  = sync ? (busy && tick && sub_q[0] && (idx_q == LAST_SYNC))
                         : (judge && (idx_q == LAST_ASYNC));
  assign end_data = dat_q;
  assign end_b9   = sync ? 1'b0 : vote;
  assign sclk_o   = (busy && sync) ? sub_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      dat_q  <= '0;
      idx_q  <= '0;
      sub_q  <= '0;
      s_lo   <= 1'b1;
      s_mid  <= 1'b1;
      line_q <= 1'b1;
    end else begin
      if (tick) line_q <= line_i;
      if (sync_start) begin
        busy  <= 1'b1;
        idx_q <= '0;
        sub_q <= '0;
      end else if (async_start) begin
        busy  <= 1'b1;
        idx_q <= '0;
        sub_q <= SW'(1);
      end else if (busy && tick) begin
        if (sync) begin
          if (!sub_q[0]) begin
            dat_q <= {line_i, dat_q[DATA_W-1:1]};
            sub_q <= SW'(1);
          end else begin
            sub_q <= '0;
            if (idx_q == LAST_SYNC) busy  <= 1'b0;
            else                    idx_q <= idx_q + 1'b1;
          end
        end else begin
          if (sub_q == MID_LO) s_lo  <= line_i;
          if (sub_q == MID)    s_mid <= line_i;
          if (judge) begin
            if (idx_q == '0) begin
              if (vote) busy <= 1'b0;
            end else if (idx_q == LAST_ASYNC) begin
              busy <= 1'b0;
            end else begin
              dat_q <= {vote, dat_q[DATA_W-1:1]};
            end
          end
          if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            idx_q <= idx_q + 1'b1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/ser_port.sv
module ser_port
  import ser_port_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [1:0]        mode,
  input  logic              rx_en,
  input  logic              mp_en,
  input  logic              tx_bit9,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_tx_done,
  input  logic              clr_rx_done,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              dat_o,
  output logic              dat_oe,
  output logic              tx_done,
  output logic              rx_done,
  output logic              rx_bit9,
  output logic [DATA_W-1:0] rx_data
);

  logic              tx_busy, tx_evt, tx_line, tx_sclk;
  logic              rx_busy, rx_sclk, rx_end, rx_end_b9, rx_load;
  logic [DATA_W-1:0] rx_end_data;

  ser_port_tx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .mode(mode),
    .wr_stb(wr_stb), .wr_data(wr_data), .bit9(tx_bit9),
    .busy(tx_busy), .done_evt(tx_evt), .line_o(tx_line), .sclk_o(tx_sclk)
  );

  ser_port_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .mode(mode),
    .rx_en(rx_en), .hold_full(rx_done), .tx_busy(tx_busy), .line_i(rxd_i),
    .busy(rx_busy), .sclk_o(rx_sclk), .end_evt(rx_end),
    .end_data(rx_end_data), .end_b9(rx_end_b9)
  );

  assign rx_load = rx_end && rx_accept(mode, mp_en, rx_end_b9, rx_done);
  assign txd_o   = (mode == MD_SYNC) ? (tx_sclk & rx_sclk) : tx_line;
  assign dat_o   = (mode == MD_SYNC) ? tx_line : 1'b1;
  assign dat_oe  = tx_busy && (mode == MD_SYNC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      rx_bit9 <= 1'b0;
      rx_data <= '0;
    end else begin
      if (tx_evt)           tx_done <= 1'b1;
      else if (clr_tx_done) tx_done <= 1'b0;
      if (rx_load) begin
        rx_done <= 1'b1;
        rx_data <= rx_end_data;
        rx_bit9 <= rx_end_b9;
      end else if (clr_rx_done) begin
        rx_done <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              mp_en,
  input logic              tx_busy,
  input logic              tx_evt,
  input logic              tx_done,
  input logic              txd_o,
  input logic              rx_load,
  input logic              rx_done,
  input logic              rx_bit9,
  input logic [DATA_W-1:0] rx_data
);

  AST_TX_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> tx_done);                                                   // R3

  AST_TX_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && mode != 2'd0) |-> txd_o);                                 // R2

  AST_RX_NO_OVERRUN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |-> !rx_done);                                                 // R10

  AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_load |=> $stable(rx_data));                                        // R10

  AST_RX_MP_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && mp_en && mode != 2'd0) |=> rx_bit9);                       // R8

  AST_RX_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(rx_load));                                    // R10

endmodule

bind ser_port ser_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mp_en(mp_en),
  .tx_busy(tx_busy), .tx_evt(tx_evt), .tx_done(tx_done), .txd_o(txd_o),
  .rx_load(rx_load), .rx_done(rx_done), .rx_bit9(rx_bit9), .rx_data(rx_data)
);

// File: tb/tb_ser_port.sv
module tb_ser_port;

  logic       clk = 1'b0;
  logic       rst_n, baud_tick, rx_en, mp_en, tx_bit9, wr_stb;
  logic       clr_tx_done, clr_rx_done, drv_rx, lb;
  logic [1:0] mode;
  logic [7:0] wr_data;
  logic       rxd_i, txd_o, dat_o, dat_oe, tx_done, rx_done, rx_bit9;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign rxd_i = lb ? txd_o : drv_rx;

  ser_port dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode(mode),
    .rx_en(rx_en), .mp_en(mp_en), .tx_bit9(tx_bit9), .wr_stb(wr_stb),
    .wr_data(wr_data), .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done),
    .rxd_i(rxd_i), .txd_o(txd_o), .dat_o(dat_o), .dat_oe(dat_oe),
    .tx_done(tx_done), .rx_done(rx_done), .rx_bit9(rx_bit9), .rx_data(rx_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_tx_done = 1'b1; clr_rx_done = 1'b1;
    @(negedge clk); clr_tx_done = 1'b0; clr_rx_done = 1'b0;
  endtask

  // mode 0 transmission, bit k on dat_o during clock low then clock high
  task automatic sync_tx(input logic [7:0] d);
    bit ok = 1;
    @(negedge clk); mode = 2'd0; rx_en = 1'b0; wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (dat_o !== d[k] || dat_oe !== 1'b1 || txd_o !== 1'b0) ok = 0;
      @(negedge clk);
      if (txd_o !== 1'b1) ok = 0;
      @(negedge clk);
    end
    chk("R1 R4 sync shift-out", ok, 1);
    chk("R1 sync done/oe", {tx_done, dat_oe}, 2'b10);
    clear_flags();
  endtask

  // mode 0 reception, bench presents bit k before the k-th rising clock
  task automatic sync_rx(input logic [7:0] d, input logic mp);
    lb = 1'b0;
    @(negedge clk); mode = 2'd0; mp_en = mp; drv_rx = d[0]; rx_en = 1'b1;
    for (int k = 1; k < 8; k++) begin
      repeat (2) @(negedge clk);
      drv_rx = d[k];
    end
    repeat (4) @(negedge clk);
    chk("R5 sync rx data", rx_data, d);
    chk("R5 sync rx flags", {rx_done, rx_bit9, txd_o}, 3'b101);
    rx_en = 1'b0; mp_en = 1'b0; drv_rx = 1'b1;
    clear_flags();
  endtask

  // async frame sent and looped back into the receiver
  task automatic async_lb(input logic [1:0] m, input logic [7:0] d, input logic b9,
                          input bit do_clr, input bit want, input string rq);
    logic [10:0] fr;
    logic [7:0]  hd;
    logic        hb, hf;
    int          nb;
    bit          ok = 1;
    nb = m[1] ? 11 : 10;
    fr = m[1] ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
    @(negedge clk); lb = 1'b1; mode = m; tx_bit9 = b9; clr_tx_done = 1'b1; clr_rx_done = do_clr;
    @(negedge clk); clr_tx_done = 1'b0; clr_rx_done = 1'b0;
    hd = rx_data; hb = rx_bit9; hf = rx_done;
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      if (txd_o !== fr[k]) ok = 0;
      if (k == nb - 2) chk({rq, " R3 done low before stop"}, tx_done, 0);
      if (k == nb - 1) chk({rq, " R3 done at stop"}, tx_done, 1);
      if (k < nb - 1) repeat (16) @(negedge clk);
    end
    chk({rq, " R2 R4 frame on line"}, ok, 1);
    repeat (10) @(negedge clk);
    chk({rq, " R3 done held"}, tx_done, 1);
    if (want) begin
      chk({rq, " rx data"}, rx_data, d);
      chk({rq, " R7 rx bit9/flag"}, {rx_done, rx_bit9}, {1'b1, (m[1] ? b9 : 1'b1)});
    end else begin
      chk({rq, " rx unchanged data"}, rx_data, hd);
      chk({rq, " rx unchanged bit9/flag"}, {rx_done, rx_bit9}, {hf, hb});
    end
  endtask

  // bench-driven async frame, 16 ticks per bit, optional glitch at tick 8 of bit gk
  task automatic drive_async(input logic [9:0] bits, input int gk);
    lb = 1'b0;
    for (int k = 0; k < 10; k++)
      for (int c = 0; c < 16; c++) begin
        drv_rx = bits[k] ^ ((k == gk) && (c == 7));
        @(negedge clk);
      end
    drv_rx = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; baud_tick = 1'b1; rx_en = 1'b0; mp_en = 1'b0; tx_bit9 = 1'b0;
    wr_stb = 1'b0; wr_data = '0; clr_tx_done = 1'b0; clr_rx_done = 1'b0;
    drv_rx = 1'b1; lb = 1'b0; mode = 2'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset idle line", {txd_o, dat_oe}, 2'b10);
    chk("R3 reset flags", {tx_done, rx_done, rx_bit9}, 3'b000);
    chk("R10 reset data", rx_data, 0);

    for (int i = 0; i < 256; i++) sync_tx(8'(i));
    for (int i = 0; i < 256; i++) sync_rx(8'(i * 37 + 5), 1'(i));

    rx_en = 1'b1;
    for (int i = 0; i < 256; i++) async_lb(2'd1, 8'(i), 1'b0, 1, 1, "R6 mode1");
    for (int i = 0; i < 128; i++) async_lb(2'd2, 8'(i * 2 + 1), 1'(i >> 1), 1, 1, "R7 mode2");
    for (int i = 0; i < 128; i++) async_lb(2'd3, 8'(i * 2), 1'(i), 1, 1, "R7 mode3");

    mp_en = 1'b1;
    async_lb(2'd2, 8'h3C, 1'b0, 1, 0, "R8 mode2 data frame dropped");
    async_lb(2'd2, 8'hA5, 1'b1, 1, 1, "R8 mode2 address frame");
    async_lb(2'd3, 8'h11, 1'b0, 1, 0, "R8 mode3 data frame dropped");
    async_lb(2'd3, 8'h7E, 1'b1, 1, 1, "R8 mode3 address frame");

    mode = 2'd1;
    clear_flags();
    drive_async({1'b0, 8'h96, 1'b0}, -1);
    chk("R9 bad stop dropped", rx_done, 0);
    drive_async({1'b1, 8'h69, 1'b0}, -1);
    chk("R9 good stop accepted", {rx_done, rx_bit9, rx_data}, {2'b11, 8'h69});
    mp_en = 1'b0;
    clear_flags();
    drive_async({1'b0, 8'hC3, 1'b0}, -1);
    chk("R9 R7 bad stop kept without filter", {rx_done, rx_bit9, rx_data}, {2'b10, 8'hC3});

    async_lb(2'd1, 8'h5A, 1'b0, 1, 1, "R10 first frame");
    async_lb(2'd1, 8'hE7, 1'b0, 0, 0, "R10 overrun frame lost");
    async_lb(2'd1, 8'h24, 1'b0, 1, 1, "R10 after clear");

    rx_en = 1'b0;
    async_lb(2'd1, 8'h81, 1'b0, 1, 0, "R11 receiver disabled");
    rx_en = 1'b1;

    clear_flags();
    lb = 1'b0;
    drv_rx = 1'b0;
    repeat (4) @(negedge clk);
    drv_rx = 1'b1;
    repeat (40) @(negedge clk);
    chk("R6 false start rejected", rx_done, 0);
    drive_async({1'b1, 8'h4B, 1'b0}, 3);
    chk("R6 majority masks glitch", {rx_done, rx_data}, {1'b1, 8'h4B});

    clear_flags();
    chk("R3 done cleared", tx_done, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule